// File: doc/BRIEF.md
# Tag-Ordered Result Bus Arbiter

This block sits between the functional units of an out-of-order core and the shared result bus that feeds the reservation stations and the register status logic. Every unit that finishes an instruction raises a completion request carrying the instruction's tag, its destination register, and a flag saying whether the result is a branch resolution. The arbiter captures these requests into a small pending buffer that it keeps sorted by tag. From that buffer it drives up to `SLOTS` bus lanes per cycle.

Grant order follows global instruction age. Each cycle the lanes carry the smallest tags pending, in ascending order, with lane 0 holding the oldest. Results that do not win a lane stay buffered. On the next cycle they compete again, including against newer arrivals that have smaller tags. A result is never broadcast in the cycle in which it is presented. It goes out at the start of the following cycle at the earliest, ahead of any scheduling that consumes it.

When the buffer cannot take a full round of requests after this cycle's grants, a stall output tells the units to hold their results. Tags are assumed unique among live results and never wrap within a run.

Top module: `tag_order_bus_arb`

## Requirements
- R1: While reset is held and right after it, no bus lane is valid and stall is low.
- R2: A request captured at a clock edge first appears on the bus in the cycle that follows that edge, never in the cycle in which it is presented.
- R3: Each cycle exactly min(pending, SLOTS) lanes are valid, contiguous from lane 0, with strictly ascending tags from lane 0 upward.
- R4: The valid lanes carry the smallest tags among all pending results.
- R5: A result shown on a lane is removed after that one cycle. Results not shown stay pending and compete again on the next cycle, where a newer request with a smaller tag overtakes them.
- R6: The tag, destination register and branch flag of a result travel together unchanged from request to lane.
- R7: Branch resolutions (flag = 1) are ordered by exactly the same tag rule as ordinary results.
- R8: Stall is high exactly when pending minus min(pending, SLOTS) exceeds DEPTH − N_UNITS. It depends only on registered state.
- R9: Requests presented while stall is high are ignored and never reach the bus.
- R10: The number of pending results never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_UNITS | Completion request per functional unit |
| req_tag | input | N_UNITS×TAG_W | Instruction tag per request |
| req_dst | input | N_UNITS×REG_W | Destination register per request |
| req_branch | input | N_UNITS | 1 = branch resolution, 0 = ordinary result |
| stall | output | 1 | Units must hold their results this cycle |
| bus_valid | output | SLOTS | Lane carries a result this cycle |
| bus_tag | output | SLOTS×TAG_W | Tag on each lane, ascending from lane 0 |
| bus_dst | output | SLOTS×REG_W | Destination register on each lane |
| bus_branch | output | SLOTS | Branch flag on each lane |

## Verification
A lone request checks the one-cycle delay before broadcast. A burst of four requests in descending tag order, mixing branch and ordinary results, shows whether the buffer sorts rather than keeping arrival order. A second batch with smaller tags, presented while older, larger tags are still waiting, separates true age ordering from first-come service. The buffer is then filled until stall rises, and low tags are offered during the stall; they would jump to lane 0 if they were wrongly captured. Seeded random traffic with out-of-order tags, compared against a sorted reference list, covers the merge of buffered and new entries under sustained overload.

// File: rtl/rba_pkg.sv
// Shared helpers for the tag-ordered result bus arbiter.
// Assumes: integer parameters only; no state lives here.
package rba_pkg;

    // Smaller of two integers, used to derive parameter limits.
    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rba_intake.sv
// Gates the completion requests of the functional units against stall.
// Assumes: a unit that sees stall high keeps its result and retries later.
// Also guards the input contract that live tags within one cycle differ.
module rba_intake #(
    parameter int N_UNITS = 4,
    parameter int TAG_W   = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_UNITS-1:0]              req_valid,
    input  logic [N_UNITS-1:0][TAG_W-1:0]   req_tag,
    input  logic                            stall,
    output logic [N_UNITS-1:0]              accept
);

    // Admit requests only when the buffer has room for a full round.
    always_comb begin
        accept = stall ? '0 : req_valid;
    end

    // Input contract: two requests in one cycle never share a tag (R4 ordering relies on it).
    for (genvar a = 0; a < N_UNITS; a++) begin : g_ua
        for (genvar b = a + 1; b < N_UNITS; b++) begin : g_ub
            p_unique_tags_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[a] && req_valid[b]) |-> (req_tag[a] != req_tag[b]));
        end
    end

endmodule

// File: rtl/rba_rank_merge.sv
// Sorts a set of candidate results by tag in one combinational step.
// Each candidate counts the valid candidates that are older than itself.
// Ties, which should not occur, are broken by lower index first. That count
// is the candidate's output position. Positions at or beyond NO are dropped.
// Assumes: the caller guarantees that fewer than NO+1 candidates are valid.
module rba_rank_merge #(
    parameter int NC    = 12,
    parameter int NO    = 8,
    parameter int TAG_W = 13,
    parameter int REG_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NC-1:0]               in_valid,
    input  logic [NC-1:0][TAG_W-1:0]    in_tag,
    input  logic [NC-1:0][REG_W-1:0]    in_dst,
    input  logic [NC-1:0]               in_br,
    output logic [NO-1:0]               out_valid,
    output logic [NO-1:0][TAG_W-1:0]    out_tag,
    output logic [NO-1:0][REG_W-1:0]    out_dst,
    output logic [NO-1:0]               out_br
);

    localparam int RK_W = $clog2(NC + 1);

    logic [RK_W-1:0] rank [NC];

    // Position of each candidate = number of valid candidates ahead of it.
    always_comb begin
        for (int i = 0; i < NC; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NC; j++) begin
                if (j != i && in_valid[j] &&
                    ((in_tag[j] < in_tag[i]) || ((in_tag[j] == in_tag[i]) && (j < i)))) begin
                    rank[i] = rank[i] + RK_W'(1);
                end
            end
        end
    end

    // Route every valid candidate to the output slot named by its rank.
    always_comb begin
        for (int p = 0; p < NO; p++) begin
            out_valid[p] = 1'b0;
            out_tag[p]   = '0;
            out_dst[p]   = '0;
            out_br[p]    = 1'b0;
            for (int i = 0; i < NC; i++) begin
                if (in_valid[i] && (rank[i] == RK_W'(p))) begin
                    out_valid[p] = 1'b1;
                    out_tag[p]   = in_tag[i];
                    out_dst[p]   = in_dst[i];
                    out_br[p]    = in_br[i];
                end
            end
        end
    end

    // No valid candidate may rank past the last kept slot.
    for (genvar g = 0; g < NC; g++) begin : g_ovf
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[g] |-> (rank[g] < RK_W'(NO)));
    end

endmodule

// File: rtl/rba_pending_store.sv
// Tag-sorted pending buffer of the result bus arbiter.
// Entry 0 always holds the smallest pending tag. Each cycle the first
// min(count, SLOTS) entries are on the bus and are dropped at the next edge.
// The survivors are merged with the newly accepted requests through the
// rank sorter and written back in order.
// Assumes: SLOTS <= DEPTH and N_UNITS <= DEPTH.
module rba_pending_store #(
    parameter int N_UNITS = 4,
    parameter int SLOTS   = 2,
    parameter int DEPTH   = 8,
    parameter int TAG_W   = 13,
    parameter int REG_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_UNITS-1:0]              acc,
    input  logic [N_UNITS-1:0][TAG_W-1:0]   acc_tag,
    input  logic [N_UNITS-1:0][REG_W-1:0]   acc_dst,
    input  logic [N_UNITS-1:0]              acc_br,
    output logic                            stall,
    output logic [SLOTS-1:0]                head_valid,
    output logic [SLOTS-1:0][TAG_W-1:0]     head_tag,
    output logic [SLOTS-1:0][REG_W-1:0]     head_dst,
    output logic [SLOTS-1:0]                head_br
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NC    = DEPTH + N_UNITS;
    localparam int GMAX  = rba_pkg::min_int(SLOTS, DEPTH);
    localparam int LIM   = DEPTH - N_UNITS;

    logic [DEPTH-1:0][TAG_W-1:0] q_tag;
    logic [DEPTH-1:0][REG_W-1:0] q_dst;
    logic [DEPTH-1:0]            q_br;
    logic [CNT_W-1:0]            q_cnt;

    logic [CNT_W-1:0]            grant;
    logic [CNT_W-1:0]            remain;

    logic [NC-1:0]               c_valid;
    logic [NC-1:0][TAG_W-1:0]    c_tag;
    logic [NC-1:0][REG_W-1:0]    c_dst;
    logic [NC-1:0]               c_br;

    logic [DEPTH-1:0]            m_valid;
    logic [DEPTH-1:0][TAG_W-1:0] m_tag;
    logic [DEPTH-1:0][REG_W-1:0] m_dst;
    logic [DEPTH-1:0]            m_br;
    logic [CNT_W-1:0]            n_cnt;

    // Lanes used this cycle and the room left for new arrivals.
    always_comb begin
        grant  = (q_cnt > CNT_W'(GMAX)) ? CNT_W'(GMAX) : q_cnt;
        remain = q_cnt - grant;
        stall  = (remain > CNT_W'(LIM));
    end

    // Survivors slide down by the grant count; new arrivals follow them.
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            c_valid[k] = (CNT_W'(k) < remain);
            c_tag[k]   = '0;
            c_dst[k]   = '0;
            c_br[k]    = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j == k + int'(grant)) begin
                    c_tag[k] = q_tag[j];
                    c_dst[k] = q_dst[j];
                    c_br[k]  = q_br[j];
                end
            end
        end
        for (int u = 0; u < N_UNITS; u++) begin
            c_valid[DEPTH+u] = acc[u];
            c_tag[DEPTH+u]   = acc_tag[u];
            c_dst[DEPTH+u]   = acc_dst[u];
            c_br[DEPTH+u]    = acc_br[u];
        end
    end

    rba_rank_merge #(
        .NC    (NC),
        .NO    (DEPTH),
        .TAG_W (TAG_W),
        .REG_W (REG_W)
    ) i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_valid),
        .in_tag    (c_tag),
        .in_dst    (c_dst),
        .in_br     (c_br),
        .out_valid (m_valid),
        .out_tag   (m_tag),
        .out_dst   (m_dst),
        .out_br    (m_br)
    );

    // Occupancy after the merge; the sorted output is packed from slot 0.
    always_comb begin
        n_cnt = '0;
        for (int p = 0; p < DEPTH; p++) begin
            n_cnt = n_cnt + CNT_W'(m_valid[p]);
        end
    end

    // Hold the sorted pending set across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cnt <= '0;
            q_tag <= '0;
            q_dst <= '0;
            q_br  <= '0;
        end else begin
            q_cnt <= n_cnt;
            q_tag <= m_tag;
            q_dst <= m_dst;
            q_br  <= m_br;
        end
    end

    // The oldest entries form the lanes of this cycle.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            head_valid[s] = (q_cnt > CNT_W'(s));
            head_tag[s]   = q_tag[s];
            head_dst[s]   = q_dst[s];
            head_br[s]    = q_br[s];
        end
    end

    // Occupancy stays within the buffer.
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CNT_W'(DEPTH));

    // While stalled nothing enters, so occupancy cannot grow.
    p_stall_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (q_cnt <= $past(q_cnt)));

    // With no arrivals, exactly the granted entries leave.
    p_drain_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == '0) |=> (q_cnt == $past(q_cnt) - $past(grant)));

    // Lanes leave the buffer in strictly ascending tag order.
    for (genvar s = 1; s < SLOTS; s++) begin : g_ord
        p_lane_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            head_valid[s] |-> (head_tag[s-1] < head_tag[s]));
    end

endmodule

// File: rtl/tag_order_bus_arb.sv
// Result bus arbiter that grants completed results strictly oldest tag first.
// Functional units raise completion requests. Accepted requests enter a sorted
// pending buffer and are broadcast on up to SLOTS lanes from the next cycle on.
// Assumes: tags are unique among live results and do not wrap during a run.
module tag_order_bus_arb #(
    parameter int N_UNITS = 4,
    parameter int SLOTS   = 2,
    parameter int DEPTH   = 8,
    parameter int TAG_W   = 13,
    parameter int REG_W   = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_UNITS-1:0]              req_valid,
    input  logic [N_UNITS-1:0][TAG_W-1:0]   req_tag,
    input  logic [N_UNITS-1:0][REG_W-1:0]   req_dst,
    input  logic [N_UNITS-1:0]              req_branch,
    output logic                            stall,
    output logic [SLOTS-1:0]                bus_valid,
    output logic [SLOTS-1:0][TAG_W-1:0]     bus_tag,
    output logic [SLOTS-1:0][REG_W-1:0]     bus_dst,
    output logic [SLOTS-1:0]                bus_branch
);

    logic [N_UNITS-1:0] accept;

    rba_intake #(
        .N_UNITS (N_UNITS),
        .TAG_W   (TAG_W)
    ) i_intake (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_tag   (req_tag),
        .stall     (stall),
        .accept    (accept)
    );

    rba_pending_store #(
        .N_UNITS (N_UNITS),
        .SLOTS   (SLOTS),
        .DEPTH   (DEPTH),
        .TAG_W   (TAG_W),
        .REG_W   (REG_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (accept),
        .acc_tag    (req_tag),
        .acc_dst    (req_dst),
        .acc_br     (req_branch),
        .stall      (stall),
        .head_valid (bus_valid),
        .head_tag   (bus_tag),
        .head_dst   (bus_dst),
        .head_br    (bus_branch)
    );

    // Valid lanes are packed from lane 0 with no gaps.
    p_lanes_packed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_valid & (bus_valid + SLOTS'(1))) == '0));

    // Right after reset the bus is idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (bus_valid == '0));

endmodule

// File: tb/test_tag_order_bus_arb.sv
// Bench: seeded random traffic plus directed corner cases, against a sorted
// reference list kept by the bench.
module test_tag_order_bus_arb;

    localparam int N  = 4;
    localparam int S  = 2;
    localparam int D  = 8;
    localparam int TW = 13;
    localparam int RW = 5;

    logic                   clk;
    logic                   rst_n;
    logic [N-1:0]           req_valid;
    logic [N-1:0][TW-1:0]   req_tag;
    logic [N-1:0][RW-1:0]   req_dst;
    logic [N-1:0]           req_branch;
    logic                   stall;
    logic [S-1:0]           bus_valid;
    logic [S-1:0][TW-1:0]   bus_tag;
    logic [S-1:0][RW-1:0]   bus_dst;
    logic [S-1:0]           bus_branch;

    tag_order_bus_arb #(
        .N_UNITS (N), .SLOTS (S), .DEPTH (D), .TAG_W (TW), .REG_W (RW)
    ) i_tag_order_bus_arb (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_tag (req_tag), .req_dst (req_dst),
        .req_branch (req_branch), .stall (stall),
        .bus_valid (bus_valid), .bus_tag (bus_tag), .bus_dst (bus_dst),
        .bus_branch (bus_branch)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  m_cnt = 0;
    int  m_tag [D];
    int  m_dst [D];
    int  m_br  [D];
    bit  used  [8192];

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int exp_stall();
        int g = (m_cnt < S) ? m_cnt : S;
        return ((m_cnt - g) > (D - N)) ? 1 : 0;
    endfunction

    // Compare all outputs against the reference list.
    task automatic check_outputs(input string rq);
        chk("R8", "stall", int'(stall), exp_stall());
        for (int s = 0; s < S; s++) begin
            chk(rq, $sformatf("lane%0d valid", s), int'(bus_valid[s]), (s < m_cnt) ? 1 : 0);
            if (s < m_cnt) begin
                chk(rq, $sformatf("lane%0d tag", s), int'(bus_tag[s]), m_tag[s]);
                chk("R6", $sformatf("lane%0d dst", s), int'(bus_dst[s]), m_dst[s]);
                chk("R6", $sformatf("lane%0d branch", s), int'(bus_branch[s]), m_br[s]);
            end
        end
    endtask

    task automatic model_insert(input int t, input int r, input int b);
        int pos = m_cnt;
        while (pos > 0 && m_tag[pos-1] > t) begin
            m_tag[pos] = m_tag[pos-1];
            m_dst[pos] = m_dst[pos-1];
            m_br[pos]  = m_br[pos-1];
            pos--;
        end
        m_tag[pos] = t;
        m_dst[pos] = r;
        m_br[pos]  = b;
        m_cnt++;
    endtask

    // Predict the state after the coming edge from the driven inputs.
    task automatic model_step();
        int st = exp_stall();
        int g  = (m_cnt < S) ? m_cnt : S;
        for (int k = 0; k < m_cnt - g; k++) begin
            m_tag[k] = m_tag[k+g];
            m_dst[k] = m_dst[k+g];
            m_br[k]  = m_br[k+g];
        end
        m_cnt -= g;
        if (st == 0) begin
            for (int u = 0; u < N; u++) begin
                if (req_valid[u]) model_insert(int'(req_tag[u]), int'(req_dst[u]), int'(req_branch[u]));
            end
        end
    endtask

    task automatic cycle(input string rq);
        check_outputs(rq);
        model_step();
        @(negedge clk);
    endtask

    task automatic set_req(input int u, input int t, input int r, input int b);
        req_valid[u]  = 1'b1;
        req_tag[u]    = TW'(t);
        req_dst[u]    = RW'(r);
        req_branch[u] = b[0];
        used[t]       = 1'b1;
    endtask

    task automatic clear_req();
        req_valid  = '0;
        req_tag    = '0;
        req_dst    = '0;
        req_branch = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd4711));
        clear_req();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle bus and no stall during reset
        chk("R1", "bus_valid in reset", int'(bus_valid), 0);
        chk("R1", "stall in reset", int'(stall), 0);
        rst_n = 1'b1;

        // R2: a single request is not visible in its own cycle
        set_req(0, 100, 3, 0);
        chk("R2", "same-cycle lane0", int'(bus_valid[0]), 0);
        cycle("R2");
        clear_req();
        chk("R2", "next-cycle lane0", int'(bus_valid[0]), 1);
        cycle("R2");
        cycle("R5");

        // R4/R7: descending burst with branch resolutions mixed in
        set_req(0, 40, 1, 1);
        set_req(1, 30, 2, 0);
        set_req(2, 20, 7, 1);
        set_req(3, 10, 9, 0);
        cycle("R4");
        clear_req();
        chk("R7", "lane0 oldest", int'(bus_tag[0]), 10);
        cycle("R7");
        cycle("R7");
        cycle("R5");

        // R5: newer requests with smaller tags overtake waiting ones
        for (int u = 0; u < 4; u++) set_req(u, 200 + u, u, 0);
        cycle("R4");
        clear_req();
        set_req(0, 150, 11, 1);
        set_req(1, 151, 12, 0);
        cycle("R5");
        clear_req();
        chk("R5", "overtake lane0", int'(bus_tag[0]), 150);
        cycle("R5");
        cycle("R5");
        cycle("R5");

        // R8: fill until stall rises
        for (int c = 0; c < 3; c++) begin
            for (int u = 0; u < 4; u++) set_req(u, 220 + 4 * c + u, u + c, c & 1);
            cycle("R8");
        end
        clear_req();
        chk("R8", "stall after fill", int'(stall), 1);
        // R9: small tags offered during stall must be dropped
        set_req(0, 5, 1, 0);
        set_req(1, 6, 2, 1);
        cycle("R9");
        clear_req();
        chk("R9", "dropped tag absent", int'(bus_tag[0] == TW'(5)), 0);
        repeat (6) cycle("R9");

        // Random out-of-order traffic
        base = 300;
        for (int it = 0; it < 900; it++) begin
            base++;
            for (int u = 0; u < N; u++) begin
                if (($urandom % 100) < 55) begin
                    int t = (base + int'($urandom % 8)) * 4 + u;
                    if (!used[t]) set_req(u, t, int'($urandom % 32), int'($urandom % 2));
                end
            end
            cycle("R4");
            clear_req();
        end
        repeat (10) cycle("R5");
        chk("R5", "empty after drain", int'(bus_valid), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule